// File: doc/BRIEF.md
# Delayed Read Restart and Flush Controller

This block sits on the read side of the queue that returns data for a delayed read served on behalf of an external bus master. Each queue entry is a 3-bit tag plus a data word. While a delayed read is pending, the block holds that read's word window. It compares the word range of every external write against this window. If a write lands inside the window, the block tells the host to reissue the read by sending a restart response. It then throws away queued entries up to and including the next terminating entry that the host inserts. Entries that arrive after that terminator are passed on, because they belong to the reissued read.

The block also reports when the delayed read is really being serviced. This happens once the host signals that all earlier writes have drained. The block consumes one queue entry in every cycle in which an entry is presented.

Top module: `dr_restart_flush`

## Requirements
- R1: After reset, `out_valid_o` and `rsp_valid_o` are low, no read is pending and no flush is in progress.
- R2: When no flush is in progress, an entry whose tag is 3'b001 (target abort), 3'b011 (fast retry), 3'b100 (data), 3'b101 (data with parity error), 3'b110 (last data) or 3'b111 (last data with parity error) appears on `out_tag_o`/`out_data_o` unchanged, with `out_valid_o` high, one cycle after it is presented.
- R3: An entry with tag 3'b000 or 3'b010 is dropped and never raises `out_valid_o`, whether or not a flush is in progress.
- R4: A write to words [wr_addr, wr_addr+wr_words) that shares at least one word with a pending read's words [rd_addr, rd_addr+rd_words) produces `rsp_code_o` = 4'h8 with `rsp_valid_o` high in the next cycle and starts a flush. Ranges that only touch end to end do not overlap.
- R5: A write produces no response when no read is pending, or when either range holds zero words.
- R6: During a flush, every entry is discarded. Tags 3'b011, 3'b100 and 3'b101 do not end the flush. The first entry tagged 3'b001, 3'b110 or 3'b111 is also discarded, and it ends the flush.
- R7: Entries presented after the entry that ended the flush are delivered as in R2.
- R8: A further overlapping write during a flush again produces 4'h8, but the flush still ends at the first terminating entry.
- R9: While a read is pending and `wr_drained_i` is high, the block emits 4'h9 once. It does not emit 4'h9 again until a restart or a new read arm.
- R10: If a restart and an unsuspend fall due in the same cycle, 4'h8 is sent first and 4'h9 follows in the next cycle if `wr_drained_i` is still high.
- R11: After `rd_done_i`, the read is no longer pending and overlapping writes produce no response.
- R12: An entry presented in the same cycle as an overlapping write is delivered, because it precedes the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_arm_i | input | 1 | Capture a new pending delayed read |
| rd_addr_i | input | ADDR_W | First word address of the read |
| rd_words_i | input | CNT_W | Number of words in the read |
| rd_done_i | input | 1 | Read finished; window released |
| wr_valid_i | input | 1 | External write seen this cycle |
| wr_addr_i | input | ADDR_W | First word address of the write |
| wr_words_i | input | CNT_W | Number of words in the write |
| wr_drained_i | input | 1 | All earlier writes are complete |
| ent_valid_i | input | 1 | Queue entry presented and consumed |
| ent_tag_i | input | 3 | Entry tag |
| ent_data_i | input | DATA_W | Entry data |
| out_valid_o | output | 1 | Delivered entry valid |
| out_tag_o | output | 3 | Delivered entry tag |
| out_data_o | output | DATA_W | Delivered entry data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 4 | Response code (4'h8 restart, 4'h9 unsuspend) |

## Verification
The assertions assume that `rd_arm_i` and `rd_done_i` never coincide with each other or with a write, and that the host inserts a terminating entry after every restart. They also assume that address plus word count stays within the widened compare range. The stimulus keeps arms, releases and writes in separate cycles and always follows a restart with a terminator. It uses short windows at low addresses, so the bench can decide overlap by walking each written word.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [2:0] tag_t;
  typedef logic [3:0] rsp_t;

  localparam tag_t TAG_IDLE0  = 3'b000;
  localparam tag_t TAG_ABORT  = 3'b001;
  localparam tag_t TAG_IDLE1  = 3'b010;
  localparam tag_t TAG_RETRY  = 3'b011;
  localparam tag_t TAG_DATA   = 3'b100;
  localparam tag_t TAG_DATA_P = 3'b101;
  localparam tag_t TAG_LAST   = 3'b110;
  localparam tag_t TAG_LAST_P = 3'b111;

  localparam rsp_t RSP_RESTART = 4'h8;
  localparam rsp_t RSP_UNSUSP  = 4'h9;

  function automatic logic tag_is_spare(tag_t t);
    return (t == TAG_IDLE0) || (t == TAG_IDLE1);
  endfunction

  function automatic logic tag_ends_burst(tag_t t);
    return (t == TAG_ABORT) || (t[2:1] == 2'b11);
  endfunction
endpackage

// File: rtl/dr_window.sv
module dr_window #(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic              done_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_words_i,
  output logic              pending_o,
  output logic              hit_o
);
  localparam int EXT_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;

  logic              pending_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  words_q;

  function automatic logic spans_meet(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] n,
                                      logic [ADDR_W-1:0] b, logic [CNT_W-1:0] m);
    logic [EXT_W-1:0] a_lo, b_lo, a_hi, b_hi;
    a_lo = EXT_W'(a);
    b_lo = EXT_W'(b);
    a_hi = a_lo + EXT_W'(n);
    b_hi = b_lo + EXT_W'(m);
    return (n != '0) && (m != '0) && (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      base_q    <= '0;
      words_q   <= '0;
    end else if (arm_i) begin
      pending_q <= 1'b1;
      base_q    <= base_i;
      words_q   <= words_i;
    end else if (done_i) begin
      pending_q <= 1'b0;
    end
  end

  assign pending_o = pending_q;
  assign hit_o     = wr_valid_i && pending_q && spans_meet(base_q, words_q, wr_addr_i, wr_words_i);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !arm_i) |=> !pending_o);
  p_no_hit_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o) |-> !hit_o);
  p_arm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> pending_o);
endmodule

// File: rtl/dr_flush_filter.sv
module dr_flush_filter
  import dr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid_i,
  input  tag_t              ent_tag_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic              restart_i,
  output logic              out_valid_o,
  output tag_t              out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              flushing_o
);
  logic flush_q, flush_d;
  logic keep_ent, spare_ent, term_in_flush;

  assign spare_ent     = ent_valid_i && tag_is_spare(ent_tag_i);
  assign keep_ent      = ent_valid_i && !tag_is_spare(ent_tag_i) && !flush_q;
  assign term_in_flush = ent_valid_i && flush_q && tag_ends_burst(ent_tag_i);

  always_comb begin
    if (flush_q) flush_d = !term_in_flush;
    else         flush_d = restart_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_tag_o   <= TAG_IDLE0;
      out_data_o  <= '0;
    end else begin
      flush_q     <= flush_d;
      out_valid_o <= keep_ent;
      if (keep_ent) begin
        out_tag_o  <= ent_tag_i;
        out_data_o <= ent_data_i;
      end
    end
  end

  assign flushing_o = flush_q;

  p_spare_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spare_ent |=> !out_valid_o);
  p_flush_discards_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing_o && ent_valid_i) |=> !out_valid_o);
  p_term_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_in_flush |=> !flushing_o);
  p_restart_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !flushing_o) |=> flushing_o);
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid_i && !flushing_o && !tag_is_spare(ent_tag_i)) |=> (out_valid_o && out_tag_o == $past(ent_tag_i)));
endmodule

// File: rtl/dr_resp_gen.sv
module dr_resp_gen
  import dr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic arm_i,
  input  logic hit_i,
  input  logic drained_i,
  output logic rsp_valid_o,
  output rsp_t rsp_code_o
);
  logic unsusp_sent_q;
  logic fire_unsusp;

  assign fire_unsusp = pending_i && drained_i && !unsusp_sent_q && !hit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unsusp_sent_q <= 1'b0;
      rsp_valid_o   <= 1'b0;
      rsp_code_o    <= '0;
    end else begin
      if (arm_i || hit_i)   unsusp_sent_q <= 1'b0;
      else if (fire_unsusp) unsusp_sent_q <= 1'b1;
      rsp_valid_o <= hit_i || fire_unsusp;
      if (hit_i)            rsp_code_o <= RSP_RESTART;
      else if (fire_unsusp) rsp_code_o <= RSP_UNSUSP;
    end
  end

  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (rsp_code_o == RSP_RESTART || rsp_code_o == RSP_UNSUSP));
  p_restart_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (rsp_valid_o && rsp_code_o == RSP_RESTART));
  p_unsusp_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_code_o == RSP_UNSUSP) |-> !(fire_unsusp));
  p_unsusp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_code_o == RSP_UNSUSP) |-> $past(drained_i));
endmodule

// File: rtl/dr_restart_flush.sv
module dr_restart_flush
  import dr_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_arm_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  rd_words_i,
  input  logic              rd_done_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_words_i,
  input  logic              wr_drained_i,
  input  logic              ent_valid_i,
  input  logic [2:0]        ent_tag_i,
  input  logic [DATA_W-1:0] ent_data_i,
  output logic              out_valid_o,
  output logic [2:0]        out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              rsp_valid_o,
  output logic [3:0]        rsp_code_o
);
  logic overlap_hit;
  logic rd_pending;
  logic flushing;

  dr_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_window (
    .clk, .rst_n,
    .arm_i(rd_arm_i), .base_i(rd_addr_i), .words_i(rd_words_i), .done_i(rd_done_i),
    .wr_valid_i, .wr_addr_i, .wr_words_i,
    .pending_o(rd_pending), .hit_o(overlap_hit)
  );

  dr_flush_filter #(.DATA_W(DATA_W)) u_filter (
    .clk, .rst_n,
    .ent_valid_i, .ent_tag_i, .ent_data_i,
    .restart_i(overlap_hit),
    .out_valid_o, .out_tag_o, .out_data_o,
    .flushing_o(flushing)
  );

  dr_resp_gen u_resp (
    .clk, .rst_n,
    .pending_i(rd_pending), .arm_i(rd_arm_i), .hit_i(overlap_hit), .drained_i(wr_drained_i),
    .rsp_valid_o, .rsp_code_o
  );

  p_flush_has_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushing) |-> (rsp_valid_o && rsp_code_o == RSP_RESTART));
endmodule

// File: tb/dr_restart_flush_tb.sv
module dr_restart_flush_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd_arm_i = 0, rd_done_i = 0, wr_valid_i = 0, wr_drained_i = 0, ent_valid_i = 0;
  logic [29:0] rd_addr_i = 0, wr_addr_i = 0;
  logic [7:0]  rd_words_i = 0, wr_words_i = 0;
  logic [2:0]  ent_tag_i = 0;
  logic [31:0] ent_data_i = 0;
  logic        out_valid_o, rsp_valid_o;
  logic [2:0]  out_tag_o;
  logic [31:0] out_data_o;
  logic [3:0]  rsp_code_o;

  int checks = 0, errors = 0, cycles = 0;
  bit run = 0;
  logic [2:0]  q_tag[$];
  logic [31:0] q_data[$];
  string       q_req[$];
  logic [3:0]  q_code[$];
  string       q_rreq[$];
  bit          pend_m = 0;
  int          base_m = 0, words_m = 0;

  always #2 clk = ~clk;

  dr_restart_flush u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (run) begin
    if (out_valid_o) begin
      checks++;
      if (q_tag.size() == 0) begin
        errors++;
        $display("FAIL R3/R6: unexpected entry actual tag %b data %h expected none", out_tag_o, out_data_o);
      end else begin
        automatic logic [2:0] et = q_tag.pop_front();
        automatic logic [31:0] ed = q_data.pop_front();
        automatic string r = q_req.pop_front();
        if (out_tag_o !== et || out_data_o !== ed) begin
          errors++;
          $display("FAIL %s: actual %b/%h expected %b/%h", r, out_tag_o, out_data_o, et, ed);
        end
      end
    end
    if (rsp_valid_o) begin
      checks++;
      if (q_code.size() == 0) begin
        errors++;
        $display("FAIL R5/R9: unexpected response actual %h expected none", rsp_code_o);
      end else begin
        automatic logic [3:0] ec = q_code.pop_front();
        automatic string r = q_rreq.pop_front();
        if (rsp_code_o !== ec) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", r, rsp_code_o, ec);
        end
      end
    end
  end

  function automatic bit model_hit(int a, int m);
    for (int w = a; w < a + m; w++)
      if (w >= base_m && w < base_m + words_m) return 1;
    return 0;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm(int a, int n);
    rd_arm_i = 1; rd_addr_i = 30'(a); rd_words_i = 8'(n);
    pend_m = 1; base_m = a; words_m = n;
    @(negedge clk); rd_arm_i = 0;
  endtask

  task automatic release_rd();
    rd_done_i = 1; pend_m = 0;
    @(negedge clk); rd_done_i = 0;
  endtask

  task automatic ent_set(logic [2:0] t, logic [31:0] d, bit pass, string r);
    ent_valid_i = 1; ent_tag_i = t; ent_data_i = d;
    if (pass) begin q_tag.push_back(t); q_data.push_back(d); q_req.push_back(r); end
  endtask

  task automatic wr_set(int a, int m, string r);
    wr_valid_i = 1; wr_addr_i = 30'(a); wr_words_i = 8'(m);
    if (pend_m && model_hit(a, m)) begin q_code.push_back(4'h8); q_rreq.push_back(r); end
  endtask

  task automatic ent(logic [2:0] t, logic [31:0] d, bit pass, string r);
    ent_set(t, d, pass, r);
    @(negedge clk); ent_valid_i = 0;
  endtask

  task automatic wr(int a, int m, string r);
    wr_set(a, m, r);
    @(negedge clk); wr_valid_i = 0;
  endtask

  task automatic expect_rsp(logic [3:0] c, string r);
    q_code.push_back(c); q_rreq.push_back(r);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    checks++;
    if (out_valid_o !== 0 || rsp_valid_o !== 0) begin
      errors++;
      $display("FAIL R1: actual out_valid %b rsp_valid %b expected 0 0", out_valid_o, rsp_valid_o);
    end
    run = 1;
    // R2 / R3: pass-through of every valid tag, spares dropped, no read pending
    ent(3'b100, 32'h1111_0000, 1, "R2");
    ent(3'b101, 32'h1111_0001, 1, "R2");
    ent(3'b000, 32'hDEAD_0000, 0, "R3");
    ent(3'b011, 32'h1111_0002, 1, "R2");
    ent(3'b010, 32'hDEAD_0001, 0, "R3");
    ent(3'b110, 32'h1111_0003, 1, "R2");
    ent(3'b111, 32'h1111_0004, 1, "R2");
    ent(3'b001, 32'h1111_0005, 1, "R2");
    // R5: write with no pending read
    wr(100, 4, "R5");
    // R4: window 100..103
    arm(100, 4);
    wr(104, 2, "R4");
    wr(98, 2, "R4");
    wr(103, 1, "R4");
    // R6 / R8 / R3: flushing
    ent(3'b100, 32'hBAD0_0001, 0, "R6");
    ent(3'b011, 32'hBAD0_0002, 0, "R6");
    ent(3'b000, 32'hBAD0_0003, 0, "R3");
    wr(99, 3, "R8");
    ent(3'b101, 32'hBAD0_0004, 0, "R6");
    ent(3'b110, 32'hBAD0_0005, 0, "R6");
    // R7 / R8: delivered after the single terminator
    ent(3'b100, 32'h2222_0001, 1, "R7");
    ent(3'b110, 32'h2222_0002, 1, "R8");
    // R9: unsuspend once
    wr_drained_i = 1; expect_rsp(4'h9, "R9");
    idle(5);
    // R10: restart wins, unsuspend next cycle
    wr_set(101, 1, "R10"); expect_rsp(4'h9, "R10");
    @(negedge clk); wr_valid_i = 0;
    idle(2);
    ent(3'b100, 32'hBAD0_0006, 0, "R6");
    ent(3'b001, 32'hBAD0_0007, 0, "R6");
    ent(3'b100, 32'h3333_0001, 1, "R7");
    // R12: entry in same cycle as overlap is delivered
    ent_set(3'b100, 32'h4444_0001, 1, "R12");
    wr_set(100, 8, "R12"); expect_rsp(4'h9, "R9");
    @(negedge clk); wr_valid_i = 0; ent_valid_i = 0;
    idle(2);
    ent(3'b111, 32'hBAD0_0008, 0, "R6");
    ent(3'b101, 32'h4444_0002, 1, "R7");
    // R11: released read ignores writes
    wr_drained_i = 0;
    idle(1);
    release_rd();
    wr(100, 4, "R11");
    ent(3'b100, 32'h5555_0001, 1, "R11");
    // R5: zero-length read window
    arm(200, 0);
    wr(200, 4, "R5");
    ent(3'b100, 32'h5555_0002, 1, "R5");
    release_rd();
    idle(4);
    checks++;
    if (q_tag.size() != 0 || q_code.size() != 0) begin
      errors++;
      $display("FAIL R4/R7: actual %0d entries %0d responses outstanding expected 0 0", q_tag.size(), q_code.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule